// File: doc/BRIEF.md
# Partitionable Array Element Datapath

This block is one processing element of a lockstep array. A central sequencer sends every element the same opcode, base address, index value and operand each cycle. Each element combines that instruction with its own local state. That state is a 64-bit accumulator, a local index register and two enable flags. The element forms its local memory address from the sum of three parts. It reads or writes a word of its local memory, or runs an arithmetic or logical operation on the accumulator.

The single adder can work on one 64-bit value, on two independent 32-bit halves, or on eight independent bytes. Carries are cut at the lane boundaries, and each lane reports its own carry and zero result. Instead of branching, a program runs a compare. The compare loads the enable flags, and those flags then mask later instructions. A masked element keeps its registers and does not write memory. In 32-bit mode each half has its own flag. In byte mode all eight lanes share one flag.

Top module: `pe_array_elem`

## Requirements
- R1: After reset the accumulator and index register are zero, both enable flags are 1, both flag vectors are zero, and no byte write enable is active.
- R2: `mem_addr` equals `base_addr + cidx_val + local index`, taken modulo 2^ADDR_W. LDX (opcode 8) loads the local index from the low ADDR_W bits of `bcast_data`.
- R3: LDA (opcode 1) loads the accumulator from `mem_rdata`. STA (opcode 2) drives the accumulator on `mem_wdata` and raises the byte enables of the active halves. Any other opcode keeps `mem_be` at zero.
- R4: With `prec_mode` 0 (64-bit), ADD (opcode 3) and SUB (opcode 4) carry across all 64 bits. The carry out lands in `lane_carry[7]`. For SUB the carry out is 1 when there is no borrow.
- R5: With `prec_mode` 1 (two 32-bit lanes), no carry crosses from bit 31 to bit 32. Each lane reports its own carry on bits 3 and 7.
- R6: With `prec_mode` 2 (eight byte lanes), every byte adds or subtracts on its own and reports its own carry on its own bit.
- R7: AND, OR and XOR (opcodes 5, 6, 7) combine the accumulator bitwise with `bcast_data`.
- R8: ADD and SUB set `lane_zero` and `lane_carry` only on the bit of each lane's top byte. All other bits of both vectors read 0.
- R9: CEQ (opcode 9) tests for equality, and CLT (opcode 10) tests whether the accumulator is unsigned-less-than `bcast_data`, lane by lane. In 64-bit mode both flags take the one result. In 32-bit mode flag h takes the result of half h. In byte mode both flags take the AND of all eight byte results. Compares leave the accumulator and the flag vectors alone.
- R10: In 64-bit and byte modes a cleared flag 0 blocks every opcode except SETEN: the accumulator, the index and the enable flags keep their values, and `mem_be` stays 0. SETEN (opcode 11) sets both flags to 1 in every case.
- R11: In 32-bit mode flag h gates the accumulator bytes and the store byte enables of half h on their own.
- R12: A compare does not update a flag whose lane is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_code | input | 4 | Broadcast opcode |
| prec_mode | input | 2 | Lane partition: 0 = 64-bit, 1 = 2x32, 2 = 8x8, 3 = 64-bit |
| base_addr | input | ADDR_W | Base address carried in the instruction |
| cidx_val | input | ADDR_W | Central index value |
| bcast_data | input | WORD_W | Broadcast operand |
| mem_rdata | input | WORD_W | Local memory read data for `mem_addr` |
| mem_addr | output | ADDR_W | Effective local memory address |
| mem_wdata | output | WORD_W | Store data (the accumulator) |
| mem_be | output | WORD_W/SLICE_W | Byte write enables |
| enable | output | 2 | Enable flags, bit h belongs to half h |
| lane_carry | output | WORD_W/SLICE_W | Lane carries, one per lane top byte |
| lane_zero | output | WORD_W/SLICE_W | Lane zero results, one per lane top byte |

## Verification
The bench builds the element with its default parameters: a 64-bit word split into 8-bit slices and an 11-bit address. At these values all three partitions exist, and a carry can be shown stopping at byte 4 and at every byte. A local index of 0x7F0 plus a small base shows the address wrapping past 2047. The tests mix 32-bit compares with byte and 64-bit instructions, so the unequal flag state from a split compare is seen gating a later compare.

// File: rtl/pe_pkg.sv
package pe_pkg;

   typedef enum logic [3:0] {
      OP_NOP   = 4'd0,
      OP_LDA   = 4'd1,
      OP_STA   = 4'd2,
      OP_ADD   = 4'd3,
      OP_SUB   = 4'd4,
      OP_AND   = 4'd5,
      OP_OR    = 4'd6,
      OP_XOR   = 4'd7,
      OP_LDX   = 4'd8,
      OP_CEQ   = 4'd9,
      OP_CLT   = 4'd10,
      OP_SETEN = 4'd11
   } pe_op_e;

   typedef enum logic [1:0] {
      PM_W64 = 2'd0,
      PM_W32 = 2'd1,
      PM_W8  = 2'd2
   } pe_mode_e;

   // slice k opens a lane under the given partition
   function automatic logic lane_start(input logic [1:0] mode, input int k, input int hb);
      case (mode)
         PM_W8:   return 1'b1;
         PM_W32:  return (k % hb) == 0;
         default: return k == 0;
      endcase
   endfunction

   // slice k closes a lane under the given partition
   function automatic logic lane_top(input logic [1:0] mode, input int k, input int hb, input int nb);
      case (mode)
         PM_W8:   return 1'b1;
         PM_W32:  return (k % hb) == (hb - 1);
         default: return k == (nb - 1);
      endcase
   endfunction

endpackage

// File: rtl/pe_split_adder.sv
module pe_split_adder
   import pe_pkg::*;
#(
   parameter int SLICE_W = 8,
   parameter int NSLICE  = 8
) (
   input  logic [1:0]                mode,
   input  logic                      sub,
   input  logic [SLICE_W*NSLICE-1:0] a,
   input  logic [SLICE_W*NSLICE-1:0] b,
   output logic [SLICE_W*NSLICE-1:0] sum,
   output logic [NSLICE-1:0]         slice_cout
);
   localparam int HB = NSLICE / 2;

   logic [SLICE_W*NSLICE-1:0] b_eff;
   logic [NSLICE-1:0]         cin;

   assign b_eff = sub ? ~b : b;

   for (genvar k = 0; k < NSLICE; k++) begin : g_slice
      if (k == 0) begin : g_first
         assign cin[k] = sub;
      end else begin : g_chain
         // a lane start takes the fresh carry-in, otherwise the ripple
         assign cin[k] = lane_start(mode, k, HB) ? sub : slice_cout[k-1];
      end
      assign {slice_cout[k], sum[k*SLICE_W +: SLICE_W]} =
         {1'b0, a[k*SLICE_W +: SLICE_W]} + {1'b0, b_eff[k*SLICE_W +: SLICE_W]}
         + {{SLICE_W{1'b0}}, cin[k]};
   end

endmodule

// File: rtl/pe_lane_flags.sv
module pe_lane_flags
   import pe_pkg::*;
#(
   parameter int SLICE_W = 8,
   parameter int NSLICE  = 8
) (
   input  logic [1:0]                mode,
   input  logic [SLICE_W*NSLICE-1:0] sum,
   input  logic [NSLICE-1:0]         slice_cout,
   output logic [NSLICE-1:0]         top_carry,
   output logic [NSLICE-1:0]         top_zero,
   output logic [1:0]                cmp_eq,
   output logic [1:0]                cmp_lt
);
   localparam int HB = NSLICE / 2;

   logic [NSLICE-1:0] slice_zero;
   logic [NSLICE-1:0] zrun;
   logic [NSLICE-1:0] top_mask;
   logic              eq_all;
   logic              lt_all;

   for (genvar k = 0; k < NSLICE; k++) begin : g_zero
      assign slice_zero[k] = (sum[k*SLICE_W +: SLICE_W] == '0);
      assign top_mask[k]   = lane_top(mode, k, HB, NSLICE);
      if (k == 0) begin : g_first
         assign zrun[k] = slice_zero[k];
      end else begin : g_run
         assign zrun[k] = slice_zero[k] & (lane_start(mode, k, HB) | zrun[k-1]);
      end
   end

   assign top_carry = slice_cout & top_mask;
   assign top_zero  = zrun & top_mask;

   // every lane equal / every lane borrowed
   assign eq_all = &(zrun | ~top_mask);
   assign lt_all = &(~slice_cout | ~top_mask);

   for (genvar h = 0; h < 2; h++) begin : g_half
      assign cmp_eq[h] = (mode == PM_W32) ? zrun[(h+1)*HB-1]        : eq_all;
      assign cmp_lt[h] = (mode == PM_W32) ? ~slice_cout[(h+1)*HB-1] : lt_all;
   end

endmodule

// File: rtl/pe_addr_gen.sv
module pe_addr_gen #(
   parameter int ADDR_W = 11
) (
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [ADDR_W-1:0] cidx_val,
   input  logic [ADDR_W-1:0] lidx_val,
   output logic [ADDR_W-1:0] eff_addr
);
   // the sum is truncated to ADDR_W bits, which gives the wrap
   assign eff_addr = base_addr + cidx_val + lidx_val;

endmodule

// File: rtl/pe_enable_ctl.sv
module pe_enable_ctl
   import pe_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] op_code,
   input  logic [1:0] mode,
   input  logic [1:0] cmp_eq,
   input  logic [1:0] cmp_lt,
   output logic [1:0] en_q,
   output logic [1:0] half_act
);
   logic [1:0] cmp_res;

   assign half_act[0] = en_q[0];
   assign half_act[1] = (mode == PM_W32) ? en_q[1] : en_q[0];
   assign cmp_res     = (op_code == OP_CLT) ? cmp_lt : cmp_eq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 2'b11;
      end else if (op_code == OP_SETEN) begin
         en_q <= 2'b11;
      end else if (op_code == OP_CEQ || op_code == OP_CLT) begin
         for (int h = 0; h < 2; h++) begin
            if (half_act[h]) en_q[h] <= cmp_res[h];
         end
      end
   end

endmodule

// File: rtl/pe_array_elem.sv
module pe_array_elem
   import pe_pkg::*;
#(
   parameter int WORD_W  = 64,
   parameter int SLICE_W = 8,
   parameter int ADDR_W  = 11
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [3:0]                op_code,
   input  logic [1:0]                prec_mode,
   input  logic [ADDR_W-1:0]         base_addr,
   input  logic [ADDR_W-1:0]         cidx_val,
   input  logic [WORD_W-1:0]         bcast_data,
   input  logic [WORD_W-1:0]         mem_rdata,
   output logic [ADDR_W-1:0]         mem_addr,
   output logic [WORD_W-1:0]         mem_wdata,
   output logic [WORD_W/SLICE_W-1:0] mem_be,
   output logic [1:0]                enable,
   output logic [WORD_W/SLICE_W-1:0] lane_carry,
   output logic [WORD_W/SLICE_W-1:0] lane_zero
);
   localparam int NBYTE = WORD_W / SLICE_W;
   localparam int HB    = NBYTE / 2;

   if (WORD_W % SLICE_W != 0) begin : g_bad_slice
      $error("WORD_W must be a multiple of SLICE_W");
   end
   if (NBYTE < 2 || NBYTE % 2 != 0) begin : g_bad_count
      $error("slice count must be even and at least 2");
   end
   if (ADDR_W < 1 || ADDR_W > WORD_W) begin : g_bad_addr
      $error("ADDR_W out of range");
   end

   logic [WORD_W-1:0] acc_q;
   logic [ADDR_W-1:0] lidx_q;
   logic [NBYTE-1:0]  carry_q;
   logic [NBYTE-1:0]  zero_q;

   logic              is_sub;
   logic [WORD_W-1:0] sum;
   logic [NBYTE-1:0]  slice_cout;
   logic [NBYTE-1:0]  top_carry;
   logic [NBYTE-1:0]  top_zero;
   logic [1:0]        cmp_eq;
   logic [1:0]        cmp_lt;
   logic [1:0]        half_act;
   logic [NBYTE-1:0]  byte_act;
   logic [WORD_W-1:0] alu_res;
   logic              writes_acc;
   logic              writes_flags;

   assign is_sub = (op_code == OP_SUB) || (op_code == OP_CEQ) || (op_code == OP_CLT);

   pe_split_adder #(.SLICE_W(SLICE_W), .NSLICE(NBYTE)) u_add (
      .mode       (prec_mode),
      .sub        (is_sub),
      .a          (acc_q),
      .b          (bcast_data),
      .sum        (sum),
      .slice_cout (slice_cout)
   );

   pe_lane_flags #(.SLICE_W(SLICE_W), .NSLICE(NBYTE)) u_flg (
      .mode       (prec_mode),
      .sum        (sum),
      .slice_cout (slice_cout),
      .top_carry  (top_carry),
      .top_zero   (top_zero),
      .cmp_eq     (cmp_eq),
      .cmp_lt     (cmp_lt)
   );

   pe_enable_ctl u_en (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_code  (op_code),
      .mode     (prec_mode),
      .cmp_eq   (cmp_eq),
      .cmp_lt   (cmp_lt),
      .en_q     (enable),
      .half_act (half_act)
   );

   pe_addr_gen #(.ADDR_W(ADDR_W)) u_ag (
      .base_addr (base_addr),
      .cidx_val  (cidx_val),
      .lidx_val  (lidx_q),
      .eff_addr  (mem_addr)
   );

   for (genvar k = 0; k < NBYTE; k++) begin : g_byte_act
      assign byte_act[k] = half_act[k / HB];
   end

   always_comb begin
      case (op_code)
         OP_LDA:  alu_res = mem_rdata;
         OP_ADD:  alu_res = sum;
         OP_SUB:  alu_res = sum;
         OP_AND:  alu_res = acc_q & bcast_data;
         OP_OR:   alu_res = acc_q | bcast_data;
         OP_XOR:  alu_res = acc_q ^ bcast_data;
         default: alu_res = acc_q;
      endcase
   end

   assign writes_acc   = (op_code == OP_LDA) || (op_code == OP_ADD) || (op_code == OP_SUB)
                      || (op_code == OP_AND) || (op_code == OP_OR)  || (op_code == OP_XOR);
   assign writes_flags = (op_code == OP_ADD) || (op_code == OP_SUB);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         carry_q <= '0;
         zero_q  <= '0;
      end else begin
         for (int k = 0; k < NBYTE; k++) begin
            if (byte_act[k] && writes_acc) acc_q[k*SLICE_W +: SLICE_W] <= alu_res[k*SLICE_W +: SLICE_W];
            if (byte_act[k] && writes_flags) begin
               carry_q[k] <= top_carry[k];
               zero_q[k]  <= top_zero[k];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lidx_q <= '0;
      end else if (op_code == OP_LDX && (|half_act)) begin
         lidx_q <= bcast_data[ADDR_W-1:0];
      end
   end

   assign mem_wdata  = acc_q;
   assign mem_be     = (op_code == OP_STA) ? byte_act : '0;
   assign lane_carry = carry_q;
   assign lane_zero  = zero_q;

endmodule

// File: rtl/pe_array_elem_chk.sv
module pe_array_elem_chk
   import pe_pkg::*;
#(
   parameter int WORD_W = 64,
   parameter int NBYTE  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        op_code,
   input logic [1:0]        prec_mode,
   input logic [WORD_W-1:0] mem_wdata,
   input logic [NBYTE-1:0]  mem_be,
   input logic [1:0]        enable,
   input logic [NBYTE-1:0]  lane_carry,
   input logic [NBYTE-1:0]  lane_zero
);
   logic acc_op;
   logic cmp_op;
   assign acc_op = (op_code == OP_LDA) || (op_code == OP_ADD) || (op_code == OP_SUB)
                || (op_code == OP_AND) || (op_code == OP_OR)  || (op_code == OP_XOR);
   assign cmp_op = (op_code == OP_CEQ) || (op_code == OP_CLT);

   AST_BE_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code != OP_STA) |-> (mem_be == '0)) else $error("byte enable outside store"); // R3

   AST_SETEN_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == OP_SETEN) |=> (enable == 2'b11)) else $error("flags not restored"); // R10

   AST_MASKED_ACC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (prec_mode != PM_W32 && !enable[0] && acc_op) |=> $stable(mem_wdata)) else $error("masked element changed acc"); // R10

   AST_MASKED_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (prec_mode != PM_W32 && !enable[0]) |-> (mem_be == '0)) else $error("masked element stored"); // R10

   AST_JOINT_FLAGS_TIED: assert property (@(posedge clk) disable iff (!rst_n)
      (prec_mode != PM_W32 && enable[0] && cmp_op) |=> (enable[0] == enable[1])) else $error("joint compare split flags"); // R9

   AST_NONTOP_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (prec_mode == PM_W64 && enable[0] && (op_code == OP_ADD || op_code == OP_SUB))
      |=> (lane_carry[NBYTE-2:0] == '0 && lane_zero[NBYTE-2:0] == '0)) else $error("flag on non-top byte"); // R8

endmodule

bind pe_array_elem pe_array_elem_chk #(.WORD_W(WORD_W), .NBYTE(WORD_W/SLICE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_code    (op_code),
   .prec_mode  (prec_mode),
   .mem_wdata  (mem_wdata),
   .mem_be     (mem_be),
   .enable     (enable),
   .lane_carry (lane_carry),
   .lane_zero  (lane_zero)
);

// File: tb/sim_pe_array_elem.sv
module sim_pe_array_elem;
   import pe_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int WORD_W = 64;
   localparam int SLICE_W = 8;
   localparam int ADDR_W = 11;
   localparam int NBYTE = WORD_W / SLICE_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [3:0]        op_code = 4'd0;
   logic [1:0]        prec_mode = 2'd0;
   logic [ADDR_W-1:0] base_addr = '0;
   logic [ADDR_W-1:0] cidx_val = '0;
   logic [WORD_W-1:0] bcast_data = '0;
   logic [WORD_W-1:0] mem_rdata;
   logic [ADDR_W-1:0] mem_addr;
   logic [WORD_W-1:0] mem_wdata;
   logic [NBYTE-1:0]  mem_be;
   logic [1:0]        enable;
   logic [NBYTE-1:0]  lane_carry;
   logic [NBYTE-1:0]  lane_zero;

   logic [WORD_W-1:0] tmem [0:(1<<ADDR_W)-1];
   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pe_array_elem #(.WORD_W(WORD_W), .SLICE_W(SLICE_W), .ADDR_W(ADDR_W)) u0 (
      .clk(clk), .rst_n(rst_n), .op_code(op_code), .prec_mode(prec_mode),
      .base_addr(base_addr), .cidx_val(cidx_val), .bcast_data(bcast_data),
      .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_be(mem_be), .enable(enable), .lane_carry(lane_carry), .lane_zero(lane_zero)
   );

   assign mem_rdata = tmem[mem_addr];

   always @(posedge clk) begin
      for (int k = 0; k < NBYTE; k++)
         if (mem_be[k]) tmem[mem_addr][k*SLICE_W +: SLICE_W] <= mem_wdata[k*SLICE_W +: SLICE_W];
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // called at a falling edge; applies one instruction for one cycle
   task automatic exec(input logic [3:0] op, input logic [1:0] md, input logic [63:0] v);
      op_code = op; prec_mode = md; bcast_data = v;
      @(posedge clk); @(negedge clk);
      op_code = OP_NOP;
   endtask

   task automatic load_acc(input logic [63:0] v);
      tmem[mem_addr] = v;
      exec(OP_LDA, PM_W64, '0);
   endtask

   task automatic store_chk(input string tag, input logic [1:0] md,
                            input logic [7:0] exp_be, input logic [63:0] exp_d);
      op_code = OP_STA; prec_mode = md;
      #1;
      chk({tag, " store be"}, 64'(mem_be), 64'(exp_be));
      chk({tag, " store data"}, mem_wdata, exp_d);
      @(posedge clk); @(negedge clk);
      op_code = OP_NOP;
   endtask

   task automatic t_reset();
      chk("R1 acc", mem_wdata, 64'h0);
      chk("R1 enable", 64'(enable), 64'h3);
      chk("R1 carry", 64'(lane_carry), 64'h0);
      chk("R1 zero", 64'(lane_zero), 64'h0);
      chk("R1 be", 64'(mem_be), 64'h0);
      chk("R1 index", 64'(mem_addr), 64'h0);
   endtask

   task automatic t_addr();
      exec(OP_LDX, PM_W64, 64'h7F0);
      base_addr = 11'h010; cidx_val = 11'h005; #1;
      chk("R2 wrap addr", 64'(mem_addr), 64'h005);
      base_addr = 11'h100; cidx_val = 11'h020; #1;
      chk("R2 addr", 64'(mem_addr), 64'h110);
      base_addr = '0; cidx_val = '0;
      exec(OP_LDX, PM_W64, 64'h0);
      chk("R2 index cleared", 64'(mem_addr), 64'h0);
   endtask

   task automatic t_load_store();
      load_acc(64'h0123_4567_89AB_CDEF);
      chk("R3 load", mem_wdata, 64'h0123_4567_89AB_CDEF);
      chk("R3 nop be", 64'(mem_be), 64'h0);
      store_chk("R3", PM_W64, 8'hFF, 64'h0123_4567_89AB_CDEF);
   endtask

   task automatic t_add64();
      load_acc(64'hFFFF_FFFF_FFFF_FFFF);
      exec(OP_ADD, PM_W64, 64'h1);
      chk("R4 add sum", mem_wdata, 64'h0);
      chk("R4 add carry", 64'(lane_carry), 64'h80);
      chk("R8 add zero", 64'(lane_zero), 64'h80);
      load_acc(64'h5);
      exec(OP_SUB, PM_W64, 64'h7);
      chk("R4 sub diff", mem_wdata, 64'hFFFF_FFFF_FFFF_FFFE);
      chk("R4 sub borrow", 64'(lane_carry), 64'h0);
      chk("R8 sub zero", 64'(lane_zero), 64'h0);
   endtask

   task automatic t_add32();
      load_acc(64'h0000_0001_FFFF_FFFF);
      exec(OP_ADD, PM_W32, 64'h0000_0000_0000_0001);
      chk("R5 split sum", mem_wdata, 64'h0000_0001_0000_0000);
      chk("R5 carry", 64'(lane_carry), 64'h08);
      chk("R8 zero 32", 64'(lane_zero), 64'h08);
   endtask

   task automatic t_add8();
      load_acc(64'h01FF_80FF_0000_7F10);
      exec(OP_ADD, PM_W8, 64'h0101_0180_0102_0101);
      chk("R6 byte sum", mem_wdata, 64'h0200_817F_0102_8011);
      chk("R6 byte carry", 64'(lane_carry), 64'h50);
      chk("R8 byte zero", 64'(lane_zero), 64'h40);
      load_acc(64'h0000_0000_0000_0100);
      exec(OP_SUB, PM_W8, 64'h0000_0000_0000_0001);
      chk("R6 byte diff", mem_wdata, 64'h0000_0000_0000_01FF);
      chk("R6 byte borrow", 64'(lane_carry), 64'hFE);
      chk("R8 byte zero sub", 64'(lane_zero), 64'hFC);
   endtask

   task automatic t_logic();
      load_acc(64'hF0F0_F0F0_F0F0_F0F0);
      exec(OP_AND, PM_W64, 64'hFF00_FF00_FF00_FF00);
      chk("R7 and", mem_wdata, 64'hF000_F000_F000_F000);
      exec(OP_OR, PM_W64, 64'h0F0F_0000_0000_000F);
      chk("R7 or", mem_wdata, 64'hFF0F_F000_F000_F00F);
      exec(OP_XOR, PM_W8, 64'hFFFF_FFFF_FFFF_FFFF);
      chk("R7 xor", mem_wdata, 64'h00F0_0FFF_0FFF_0FF0);
   endtask

   task automatic t_cmp64();
      load_acc(64'h2A);
      exec(OP_CEQ, PM_W64, 64'h2A);
      chk("R9 eq true", 64'(enable), 64'h3);
      exec(OP_CLT, PM_W64, 64'd100);
      chk("R9 lt true", 64'(enable), 64'h3);
      exec(OP_CLT, PM_W64, 64'd10);
      chk("R9 lt false", 64'(enable), 64'h0);
      exec(OP_ADD, PM_W64, 64'h1);
      chk("R10 masked add", mem_wdata, 64'h2A);
      exec(OP_LDA, PM_W8, '0);
      chk("R10 masked load", mem_wdata, 64'h2A);
      store_chk("R10 masked", PM_W64, 8'h00, 64'h2A);
      exec(OP_LDX, PM_W64, 64'h123);
      chk("R10 masked index", 64'(mem_addr), 64'h0);
      exec(OP_CEQ, PM_W64, 64'h2A);
      chk("R12 masked compare", 64'(enable), 64'h0);
      exec(OP_SETEN, PM_W64, '0);
      chk("R10 seten", 64'(enable), 64'h3);
   endtask

   task automatic t_cmp32();
      load_acc(64'h0000_0005_0000_0009);
      exec(OP_CLT, PM_W32, 64'h0000_0007_0000_0007);
      chk("R9 split lt", 64'(enable), 64'h2);
      exec(OP_ADD, PM_W32, 64'h0000_0001_0000_0001);
      chk("R11 half add", mem_wdata, 64'h0000_0006_0000_0009);
      store_chk("R11 half", PM_W32, 8'hF0, 64'h0000_0006_0000_0009);
      exec(OP_CEQ, PM_W32, 64'h0000_0006_0000_0009);
      chk("R12 half compare", 64'(enable), 64'h2);
      exec(OP_SETEN, PM_W8, '0);
      chk("R10 seten split", 64'(enable), 64'h3);
   endtask

   task automatic t_cmp8();
      load_acc(64'h0101_0101_0101_0101);
      exec(OP_CEQ, PM_W8, 64'h0101_0101_0101_0101);
      chk("R9 byte eq all", 64'(enable), 64'h3);
      exec(OP_CEQ, PM_W8, 64'h0101_0101_0101_0100);
      chk("R9 byte eq one off", 64'(enable), 64'h0);
      exec(OP_SETEN, PM_W8, '0);
      exec(OP_CLT, PM_W8, 64'h0202_0202_0202_0202);
      chk("R9 byte lt all", 64'(enable), 64'h3);
      exec(OP_CLT, PM_W8, 64'h0202_0202_0202_0201);
      chk("R9 byte lt one off", 64'(enable), 64'h0);
      exec(OP_SETEN, PM_W8, '0);
      chk("R9 compare keeps acc", mem_wdata, 64'h0101_0101_0101_0101);
   endtask

   initial begin
      for (int i = 0; i < (1 << ADDR_W); i++) tmem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_addr();
      t_load_store();
      t_add64();
      t_add32();
      t_add8();
      t_logic();
      t_cmp64();
      t_cmp32();
      t_cmp8();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule